// File: doc/BRIEF.md
# SPI Frame Command Engine

This block runs one SPI frame per command word. A command picks one of four chip-select lines, a byte count, a transmit-only flag and a number of leading received bytes to drop. Each chip-select line has its own configuration word that sets the character width (4 to 16 bits), the bit order, the active level of the line, the delay from assertion to the first clock, the delay from the last clock to negation, and an idle gap between characters.

Transmit bytes are taken from an external transmit FIFO through a pop strobe and received bytes are handed to an external receive FIFO through a push strobe. The serial clock idles low; the peripheral samples data on the rising edge and the engine also samples the input line there. A one-cycle prescaler strobe paces all serial timing, one strobe per half clock period and per delay unit. When the last byte has been shifted and the hold delay has run out, the line is released and a one-cycle done pulse is raised.

Top module: `spi_cmd_engine`

## Requirements
- R1: While idle, a cycle with `cmd_valid` high starts a frame on the line given by command bits 31:30; only that line goes active, others keep their idle level. Configuration bit 20 of each line sets its level: 1 means active-low (idle high), 0 means active-high (idle low).
- R2: Command bits LEN_W-1:0 hold the byte count minus one; exactly that many bytes are popped, so a frame can reach 2**LEN_W bytes.
- R3: The character width is configuration bits 19:16 plus one. A width of 8 or less takes one byte per character (its low bits); a wider character takes two bytes, the first popped being the upper eight bits; a lone final byte of a wide frame forms the upper half with a zero lower half.
- R4: Configuration bit 29 set sends and receives each character most significant bit first; clear sends it least significant bit first.
- R5: The serial clock idles low and is high only while busy; each `tick` advances half a bit period, and the output bit is stable at each rising edge.
- R6: Configuration bits 15:12 add that many ticks between line assertion and the first clock; bits 11:8 add that many ticks between the last clock and line negation.
- R7: Configuration bits 7:3 add that many ticks between consecutive characters of a frame.
- R8: Received characters are pushed as bytes in the same packing as R3 (narrow characters zero-extended); with command bit 27 set nothing is pushed.
- R9: Command bits 16 upward (SKIP_W bits) give a count of leading received bytes that are dropped rather than pushed.
- R10: While the transmit FIFO is empty inside a frame the serial clock stays low and the line stays active until data arrives.
- R11: At frame end `done` is high for exactly one cycle, in the same cycle that `busy` falls and the line returns to idle.
- R12: A command presented while busy is ignored: no other line is touched and the running frame's byte count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 32 | Command word |
| cs_cfg | input | 128 | Four per-line configuration words, line n in bits 32n+31:32n |
| tick | input | 1 | Prescaler strobe |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_push | output | 1 | Receive FIFO push |
| rx_data | output | 8 | Byte to receive FIFO |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame complete pulse |

## Verification
The bench builds the engine with LEN_W=4 and SKIP_W=8, so the largest frame is 16 bytes and the all-ones length field is reachable in a few hundred cycles. With the input looped back from the output, it sweeps every character width from 4 to 16 in both bit orders over odd and even byte counts, and compares the serial bit stream and the pushed bytes against values computed from the packing rules. Delay and gap fields are checked as cycle differences between two settings under a constant strobe, with one run at a slower strobe.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int LEN_W  = 16,
  parameter int SKIP_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [31:0]  cmd_word,
  input  logic [127:0] cs_cfg,
  input  logic         tick,
  input  logic         tx_empty,
  input  logic [7:0]   tx_data,
  output logic         tx_pop,
  output logic         rx_push,
  output logic [7:0]   rx_data,
  output logic         sck,
  output logic         mosi,
  input  logic         miso,
  output logic [3:0]   cs_o,
  output logic         busy,
  output logic         done
);
  localparam int NCS = 4;
  localparam int CW  = 32;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_SHIFT, S_PUSH, S_GAP, S_HOLD} st_t;

  st_t               st;
  logic [1:0]        sel;
  logic              txo, msb_q, ph, sck_q, bcnt, done_q;
  logic [SKIP_W-1:0] skip_q;
  logic [LEN_W:0]    rem;
  logic [3:0]        lm1, bef_q, aft_q, idx;
  logic [4:0]        gap_q, dcnt;
  logic [15:0]       sh, rx;

  logic [CW-1:0]  ncfg;
  logic           wide, nb2, last_b;
  logic [3:0]     pos;
  logic [LEN_W:0] step;

  assign ncfg   = cs_cfg[{cmd_word[31:30], 5'd0} +: CW];
  assign wide   = lm1[3];
  assign nb2    = wide && (rem > (LEN_W+1)'(1));
  assign last_b = nb2 ? bcnt : 1'b1;
  assign step   = {{(LEN_W-1){1'b0}}, nb2, !nb2};
  assign pos    = msb_q ? lm1 - idx : idx;

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign sck     = sck_q;
  assign mosi    = (st == S_SHIFT) && sh[pos];
  assign tx_pop  = (st == S_LOAD) && !tx_empty;
  assign rx_push = (st == S_PUSH) && !txo && (skip_q == '0);
  assign rx_data = (wide && !bcnt) ? rx[15:8] : rx[7:0];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_o[i] = (busy && sel == i) ^ cs_cfg[i*CW+20];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sel <= '0; txo <= 1'b0; msb_q <= 1'b0; ph <= 1'b0;
      sck_q <= 1'b0; bcnt <= 1'b0; done_q <= 1'b0; skip_q <= '0; rem <= '0;
      lm1 <= '0; bef_q <= '0; aft_q <= '0; idx <= '0; gap_q <= '0;
      dcnt <= '0; sh <= '0; rx <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          sel    <= cmd_word[31:30];
          txo    <= cmd_word[27];
          skip_q <= cmd_word[16 +: SKIP_W];
          rem    <= {1'b0, cmd_word[LEN_W-1:0]} + (LEN_W+1)'(1);
          msb_q  <= ncfg[29];
          lm1    <= ncfg[19:16];
          bef_q  <= ncfg[15:12];
          aft_q  <= ncfg[11:8];
          gap_q  <= ncfg[7:3];
          dcnt   <= '0;
          bcnt   <= 1'b0;
          st     <= S_SETUP;
        end
        S_SETUP:
          if (dcnt == {1'b0, bef_q}) st <= S_LOAD;
          else if (tick) dcnt <= dcnt + 5'd1;
        S_LOAD: if (!tx_empty) begin
          if (!wide) sh <= {8'h00, tx_data};
          else if (!bcnt) sh <= {tx_data, 8'h00};
          else sh[7:0] <= tx_data;
          if (last_b) begin
            bcnt <= 1'b0; idx <= '0; ph <= 1'b0; rx <= '0; st <= S_SHIFT;
          end else bcnt <= 1'b1;
        end
        S_SHIFT: if (tick) begin
          if (!ph) begin
            sck_q <= 1'b1; rx[pos] <= miso; ph <= 1'b1;
          end else begin
            sck_q <= 1'b0; ph <= 1'b0;
            if (idx == lm1) begin bcnt <= 1'b0; st <= S_PUSH; end
            else idx <= idx + 4'd1;
          end
        end
        S_PUSH: begin
          if (!txo && skip_q != '0) skip_q <= skip_q - 1'b1;
          if (last_b) begin
            rem  <= rem - step;
            bcnt <= 1'b0;
            dcnt <= '0;
            st   <= (rem == step) ? S_HOLD : S_GAP;
          end else bcnt <= 1'b1;
        end
        S_GAP:
          if (dcnt == gap_q) st <= S_LOAD;
          else if (tick) dcnt <= dcnt + 5'd1;
        S_HOLD:
          if (dcnt == {1'b0, aft_q}) begin st <= S_IDLE; done_q <= 1'b1; end
          else if (tick) dcnt <= dcnt + 5'd1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_cmd_engine_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         sck,
  input logic         tx_pop,
  input logic         rx_push,
  input logic [3:0]   cs_o,
  input logic [127:0] cs_cfg
);
  logic [3:0] act;
  always_comb
    for (int i = 0; i < 4; i++) act[i] = cs_o[i] ^ cs_cfg[i*32+20];

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act));
  // R1
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (act != 4'b0) |-> busy);
  // R5
  sck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) sck |-> busy);
  // R10
  pop_low_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !sck);
  // R8
  push_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sck(sck),
  .tx_pop(tx_pop), .rx_push(rx_push), .cs_o(cs_o), .cs_cfg(cs_cfg)
);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  logic clk = 0, rst_n = 0, cmd_valid = 0, tx_pop, rx_push, sck, mosi, miso, busy, done;
  logic [31:0] cmd_word = '0;
  logic [127:0] cs_cfg;
  logic [7:0] tx_data, rx_data;
  logic [3:0] cs_o;
  logic tick, tx_empty, tslow = 0;
  logic [1:0] tc = 0;
  int checks = 0, fails = 0;
  logic [7:0] txm [0:511];
  logic [7:0] rxm [0:511];
  logic sb [0:1023];
  int txw = 0, txr = 0, rxn = 0, sbn = 0;
  int cur_L = 8;
  bit cur_msb = 1;

  always #2.5 clk = ~clk;
  always @(posedge clk) tc <= tc + 2'd1;
  assign tick     = tslow ? (tc == 2'd0) : 1'b1;
  assign tx_empty = (txr >= txw);
  assign tx_data  = txm[txr % 512];
  assign miso     = mosi;

  always @(posedge clk) if (tx_pop) txr <= txr + 1;
  always @(posedge clk) if (rx_push) begin rxm[rxn % 512] <= rx_data; rxn <= rxn + 1; end
  always @(posedge sck) begin sb[sbn % 1024] <= mosi; sbn <= sbn + 1; end

  spi_cmd_engine #(.LEN_W(4), .SKIP_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cs_cfg(cs_cfg),
    .tick(tick), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o), .busy(busy), .done(done));

  function automatic logic [31:0] mk_cfg(bit msb, bit actlow, int L, int bef, int aft, int gap);
    return {2'b00, msb, 8'h00, actlow, 4'(L-1), 4'(bef), 4'(aft), 5'(gap), 3'b000};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int cs, input int n, input bit txo, input int skip,
                           input bit stall, input bit inj,
                           output int t_setup, output int t_hold, output int t_gap);
    int base_tx = txw, base_rx = rxn, base_sb = sbn;
    int rt [0:255];
    int nr = 0, cyc = 0, t_end = 0, bad = 0, ebits = 0, erx = 0, bmis = 0, rmis = 0, k = 0;
    bit prev = 0, seen = 0, idle_lvl;
    logic [7:0] eb [0:31];
    logic [15:0] c, mask;
    idle_lvl = cs_cfg[cs*32+20];
    for (int i = 0; i < n; i++) txm[(base_tx + i) % 512] = 8'((i * 73 + n * 29 + cur_L * 5 + 17) & 255);
    txw = base_tx + (stall ? 1 : n);
    @(negedge clk);
    cmd_valid = 1;
    cmd_word = {2'(cs), 1'b0, 1'b0, txo, 3'b000, 8'(skip), 16'(n - 1)};
    @(negedge clk);
    cmd_valid = 0;
    while (!seen && cyc < 5000) begin
      if (sck && !prev) begin rt[nr % 256] = cyc; nr++; end
      prev = sck;
      if (done) begin seen = 1; t_end = cyc; end
      if (stall && cyc >= 40 && cyc < 80 && (sck || cs_o[cs] == idle_lvl)) bad++;
      if (stall && cyc == 80) txw = base_tx + n;
      if (inj && cyc == 10) begin cmd_valid = 1; cmd_word = {2'd2, 6'd0, 8'd0, 16'd0}; end
      if (inj && cyc == 11) cmd_valid = 0;
      if (inj && cs_o[2] != cs_cfg[2*32+20]) bad++;
      @(negedge clk);
      cyc++;
    end
    chk(seen, "R11 done seen", seen, 1);
    chk(!done && !busy && cs_o[cs] == idle_lvl, "R11 done one cycle, line idle", {done, busy}, 0);
    if (stall) chk(bad == 0, "R10 stall holds clock low and line active", bad, 0);
    if (inj) begin
      repeat (20) begin @(negedge clk); if (cs_o[2] != cs_cfg[2*32+20] || busy) bad++; end
      chk(bad == 0, "R12 command while busy ignored", bad, 0);
    end
    chk(txr - base_tx == n, "R2 bytes popped", txr - base_tx, n);
    mask = 16'((32'd1 << cur_L) - 1);
    k = 0;
    while (k < n) begin
      int nbt;
      if (cur_L <= 8) begin c = {8'h00, txm[(base_tx + k) % 512]} & mask; nbt = 1; end
      else if (k + 1 < n) begin c = {txm[(base_tx + k) % 512], txm[(base_tx + k + 1) % 512]} & mask; nbt = 2; end
      else begin c = {txm[(base_tx + k) % 512], 8'h00} & mask; nbt = 1; end
      for (int b = 0; b < cur_L; b++) begin
        int p = cur_msb ? cur_L - 1 - b : b;
        if (sb[(base_sb + ebits) % 1024] !== c[p]) bmis++;
        ebits++;
      end
      for (int j = 0; j < nbt; j++) begin
        logic [7:0] rb = (cur_L > 8 && j == 0) ? c[15:8] : c[7:0];
        if (k + j >= skip && !txo) begin
          if (rxm[(base_rx + erx) % 512] !== rb) rmis++;
          erx++;
        end
      end
      k += nbt;
    end
    chk(sbn - base_sb == ebits && bmis == 0, "R3 R4 serial bits", bmis, 0);
    chk(rxn - base_rx == erx && rmis == 0, txo ? "R8 transmit-only pushes none" :
        (skip > 0 ? "R9 skipped bytes" : "R8 received bytes"), rxn - base_rx, erx);
    t_setup = (nr > 0) ? rt[0] : -1;
    t_hold  = (nr > 0) ? t_end - rt[(nr - 1) % 256] : -1;
    t_gap   = (nr > cur_L) ? rt[cur_L] - rt[cur_L - 1] : -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int s0, h0, g0, s1, h1, g1, sa, ha, ga;
    cs_cfg = {mk_cfg(1, 1, 8, 0, 0, 1), mk_cfg(1, 1, 8, 0, 0, 1),
              mk_cfg(1, 0, 8, 0, 0, 1), mk_cfg(1, 1, 8, 0, 0, 1)};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset: idle levels, line 1 active-high
    chk(cs_o == 4'b1101 && !busy && !sck && !done, "R1 R5 reset state", cs_o, 13);

    // R3 R4 R8 sweep of widths and bit order
    for (int L = 4; L <= 16; L++)
      for (int m = 0; m < 2; m++) begin
        cur_L = L; cur_msb = m[0];
        cs_cfg[0 +: 32] = mk_cfg(m[0], 1, L, 0, 0, 1);
        run_frame(0, (L > 8) ? 4 : 3, 0, 0, 0, 0, sa, ha, ga);
        run_frame(0, (L > 8) ? 2 : 1, 0, 0, 0, 0, sa, ha, ga);
      end
    // R3 odd byte count with wide characters
    cur_L = 12; cur_msb = 1; cs_cfg[0 +: 32] = mk_cfg(1, 1, 12, 0, 0, 1);
    run_frame(0, 3, 0, 0, 0, 0, sa, ha, ga);

    // R1 active-high line 1
    cur_L = 8; cur_msb = 1;
    cs_cfg[32 +: 32] = mk_cfg(1, 0, 8, 2, 1, 1);
    @(negedge clk);
    cmd_valid = 1; cmd_word = {2'd1, 30'd0};
    @(negedge clk); cmd_valid = 0;
    txw = txw + 1; txm[(txw - 1) % 512] = 8'h5a;
    chk(cs_o == 4'b1111, "R1 active-high line asserted alone", cs_o, 15);
    while (busy) @(negedge clk);
    chk(cs_o == 4'b1101, "R1 line 1 back to idle", cs_o, 13);
    rxn = rxn;

    // R2 largest frame for LEN_W=4
    cs_cfg[0 +: 32] = mk_cfg(1, 1, 8, 0, 0, 1);
    run_frame(0, 16, 0, 0, 0, 0, sa, ha, ga);
    // R8 transmit only
    run_frame(0, 5, 1, 0, 0, 0, sa, ha, ga);
    // R9 skip
    run_frame(0, 5, 0, 2, 0, 0, sa, ha, ga);
    run_frame(0, 3, 0, 3, 0, 0, sa, ha, ga);
    // R10 stall
    run_frame(0, 3, 0, 0, 1, 0, sa, ha, ga);
    // R12 command while busy
    run_frame(0, 4, 0, 0, 0, 1, sa, ha, ga);

    // R6 R7 delays as differences
    cur_L = 4; cur_msb = 1;
    cs_cfg[0 +: 32] = mk_cfg(1, 1, 4, 0, 0, 1);
    run_frame(0, 2, 0, 0, 0, 0, s0, h0, g0);
    cs_cfg[0 +: 32] = mk_cfg(1, 1, 4, 5, 3, 6);
    run_frame(0, 2, 0, 0, 0, 0, s1, h1, g1);
    chk(s1 - s0 == 5, "R6 setup delay", s1 - s0, 5);
    chk(h1 - h0 == 3, "R6 hold delay", h1 - h0, 3);
    chk(g1 - g0 == 5, "R7 character gap", g1 - g0, 5);

    // R5 slow strobe: bit period four cycles per half
    tslow = 1;
    cs_cfg[0 +: 32] = mk_cfg(0, 1, 6, 0, 0, 1);
    cur_L = 6; cur_msb = 0;
    run_frame(0, 2, 0, 0, 0, 0, sa, ha, ga);
    chk(ga >= 8, "R5 tick paces clock", ga, 8);
    tslow = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule